// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer Pair

The block holds two 16-bit up-counting timers that share one 8-bit global configuration register. Each timer has a mode register, a reference register, a capture register, a counter and an event register. It counts on cycles where the shared tick input is high, flags a reference event when the count reaches the reference value, and latches its count when its capture input rises. Each timer drives its own interrupt output from its event flags and the enables in its mode register.

Setting the cascade bit joins the two timers into one 32-bit timer. The second timer then takes control: its mode register, its run and stop bits, its capture input and its event register govern the joined timer. The joined reference, counter and capture registers are reached only through full 32-bit accesses at the second timer's addresses. The second timer's half is on the upper data lanes. A single write to the global register can start, stop or clear both timers together.

The bus is single-cycle. A write takes effect on the clock edge where `bus_en_i` and `bus_we_i` are both high. Reads are combinational from `bus_addr_i`. `bus_addr_i[3]` selects the timer (0 = first, 1 = second). `bus_addr_i[2:0]` selects the register:

| Code | Register |
|---|---|
| 0 | global configuration (first timer only; 8 unused) |
| 1 | mode |
| 2 | reference |
| 3 | capture |
| 4 | counter |
| 5 | event |

Top module: `tmr_pair`

## Requirements
- R1: After reset the global register, every counter, reference, capture, mode and event register reads 0 and both interrupt outputs are low.
- R2: The global register bits are, from bit 7 down: cascade, reserved, stop second, run second, gate first, reserved, stop first, run first. Reserved bits 6 and 2 always read 0, so writing 0xFF reads back 0xBB.
- R3: While a timer's run bit is 0 its counter is held at 0. While run is 1 and stop is 0, the counter advances by one on each cycle with the tick input high.
- R4: While a timer's stop bit is 1 its counter does not advance. Its registers, including the counter, can still be written and read. Clearing the stop bit resumes counting from the held value.
- R5: One write to the global register starts both timers on the same edge, so equal tick streams give equal counts.
- R6: On a counting tick where the counter equals the reference, event bit 0 is set. If mode bit 2 (restart) is 1 the counter becomes 0; otherwise it advances normally.
- R7: A timer's interrupt output is high exactly while (event bit 0 and mode bit 0) or (event bit 1 and mode bit 1) holds.
- R8: A rising edge on a timer's capture input copies its counter into its capture register and sets event bit 1. The input is synchronized by two flops, and the capture register is loaded 3 clock edges after the input rises.
- R9: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R10: With cascade set, the two counters form one 32-bit counter that carries from the low half into the high half. A 32-bit access at the second timer's reference, capture or counter address reaches the joined value, with the second timer's half on data bits 31:16.
- R11: With cascade set, the first timer's mode register and its run and stop bits are ignored. The second timer's restart and enable bits and its run and stop bits govern the joined timer.
- R12: With cascade set, only the second capture input triggers a capture, and it loads all 32 counter bits on the same edge. The first capture input has no effect.
- R13: With cascade set, reference and capture events appear only in the second timer's event register. The first timer's event register and interrupt output stay at 0.
- R14: With cascade set, 16-bit accesses to reference, capture or counter addresses of either timer write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Count enable, one count per high cycle |
| cap_i | input | 2 | Capture inputs, bit 0 first timer, bit 1 second |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access on bits 15:0 |
| bus_addr_i | input | 4 | Bit 3 timer select, bits 2:0 register code |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 2 | Interrupt per timer |

## Verification
A register write or a counting tick shows up in the read data at the next falling edge, one register stage after the edge that took it. The bench drives every input on a falling edge and samples one falling edge later, or more. A capture passes through two synchronizer flops and an edge flop, so it lands on the third rising edge after the input rises. The bench holds each capture pulse for five cycles and reads only after a further five. Interrupts follow the event and mode registers combinationally, so they are checked on the same falling edge as the event register read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] RG_GCFG = 3'd0;
  localparam logic [2:0] RG_MODE = 3'd1;
  localparam logic [2:0] RG_REF  = 3'd2;
  localparam logic [2:0] RG_CAP  = 3'd3;
  localparam logic [2:0] RG_CNT  = 3'd4;
  localparam logic [2:0] RG_EVT  = 3'd5;

  localparam int unsigned MODE_W     = 3;
  localparam int unsigned EVT_W      = 2;
  localparam int unsigned MB_REF_IE  = 0;
  localparam int unsigned MB_CAP_IE  = 1;
  localparam int unsigned MB_RESTART = 2;
  localparam int unsigned EV_REF     = 0;
  localparam int unsigned EV_CAP     = 1;

  localparam logic [7:0] GCFG_WMASK = 8'hBB;

  typedef struct packed {
    logic cas;
    logic rsv_hi;
    logic stop_b;
    logic run_b;
    logic gate_a;
    logic rsv_lo;
    logic stop_a;
    logic run_a;
  } gcfg_t;
endpackage

// File: rtl/tmr_gcfg.sv
module tmr_gcfg
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output gcfg_t      cfg
);
  gcfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = gcfg_t'(wdata & GCFG_WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

  AST_RSV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC_N-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb sh_d = {sh_q[SYNC_N-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[SYNC_N-1];
    end
  end

  assign rise = sh_q[SYNC_N-1] & ~prev_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R8
endmodule

// File: rtl/tmr_slice.sv
module tmr_slice
  import tmr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic              ld_cnt,
  input  logic              wr_ref,
  input  logic [W-1:0]      wdat,
  input  logic              wr_mode,
  input  logic              wr_evt,
  input  logic [MODE_W-1:0] ctl,
  input  logic              cap_ld,
  input  logic              set_ref,
  input  logic              set_cap,
  output logic [W-1:0]      cnt,
  output logic [W-1:0]      refv,
  output logic [W-1:0]      cap,
  output logic [MODE_W-1:0] mode,
  output logic [EVT_W-1:0]  evt
);
  logic [W-1:0]      cnt_q, cnt_d, ref_q, ref_d, cap_q, cap_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [EVT_W-1:0]  evt_q, evt_d, evt_set, evt_clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (ld_cnt) cnt_d = wdat;
    else if (inc)    cnt_d = cnt_q + 1'b1;

    ref_d  = wr_ref  ? wdat : ref_q;
    cap_d  = cap_ld  ? cnt_q : cap_q;
    mode_d = wr_mode ? ctl : mode_q;

    evt_set = '0;
    evt_set[EV_REF] = set_ref;
    evt_set[EV_CAP] = set_cap;
    evt_clr = wr_evt ? ctl[EVT_W-1:0] : '0;
    evt_d   = (evt_q & ~evt_clr) | evt_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      mode_q <= '0;
      evt_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      ref_q  <= ref_d;
      cap_q  <= cap_d;
      mode_q <= mode_d;
      evt_q  <= evt_d;
    end
  end

  assign cnt  = cnt_q;
  assign refv = ref_q;
  assign cap  = cap_q;
  assign mode = mode_q;
  assign evt  = evt_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld_cnt && !inc) |=> $stable(cnt_q)); // R4
  AST_EVT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ctl[EV_REF] && !set_ref) |=> !evt_q[EV_REF]); // R9
  AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ld |=> cap_q == $past(cnt_q)); // R8
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned DW    = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [1:0]    cap_i,
  input  logic          bus_en_i,
  input  logic          bus_we_i,
  input  logic          bus_wide_i,
  input  logic [3:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic [1:0]    irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  gcfg_t      cfg;
  logic       wr, tsel, cas;
  logic [2:0] rsel;

  assign wr   = bus_en_i & bus_we_i;
  assign tsel = bus_addr_i[3];
  assign rsel = bus_addr_i[2:0];
  assign cas  = cfg.cas;

  tmr_gcfg u_gcfg (
    .clk   (clk),
    .rst_n (rst_ns),
    .we    (wr && !tsel && rsel == RG_GCFG),
    .wdata (bus_wdata_i[7:0]),
    .cfg   (cfg)
  );

  logic [1:0] rise;
  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_edge
      tmr_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_ns),
        .din   (cap_i[gi]),
        .rise  (rise[gi])
      );
    end
  endgenerate

  logic [W-1:0]      cnt_s [2];
  logic [W-1:0]      ref_s [2];
  logic [W-1:0]      cap_s [2];
  logic [MODE_W-1:0] mode_s [2];
  logic [EVT_W-1:0]  evt_s [2];
  logic [1:0] clr_s, inc_s, ld_s, wref_s, wmode_s, wevt_s, capld_s, sref_s, scap_s;
  logic [1:0] en_n, match_n;
  logic       en_c, match_c, wrap_c, wide_ref, wide_cnt;

  always_comb begin
    en_n[0]  = tick_i & cfg.run_a & ~cfg.stop_a;
    en_n[1]  = tick_i & cfg.run_b & ~cfg.stop_b;
    match_n[0] = cnt_s[0] == ref_s[0];
    match_n[1] = cnt_s[1] == ref_s[1];
    en_c    = en_n[1];
    match_c = match_n[0] & match_n[1];
    wrap_c  = en_c & match_c & mode_s[1][MB_RESTART];
    wide_ref = wr & cas & bus_wide_i & tsel & (rsel == RG_REF);
    wide_cnt = wr & cas & bus_wide_i & tsel & (rsel == RG_CNT);

    for (int i = 0; i < 2; i++) begin
      wmode_s[i] = wr && (tsel == i[0]) && rsel == RG_MODE;
      wevt_s[i]  = wr && (tsel == i[0]) && rsel == RG_EVT;
      if (cas) begin
        wref_s[i] = wide_ref;
        ld_s[i]   = wide_cnt;
      end else begin
        wref_s[i] = wr && (tsel == i[0]) && rsel == RG_REF;
        ld_s[i]   = wr && (tsel == i[0]) && rsel == RG_CNT;
      end
    end

    if (cas) begin
      clr_s[0]   = ~cfg.run_b | wrap_c;
      clr_s[1]   = ~cfg.run_b | wrap_c;
      inc_s[0]   = en_c;
      inc_s[1]   = en_c & (&cnt_s[0]);
      sref_s[0]  = 1'b0;
      sref_s[1]  = en_c & match_c;
      capld_s[0] = rise[1];
      capld_s[1] = rise[1];
      scap_s[0]  = 1'b0;
      scap_s[1]  = rise[1];
    end else begin
      for (int i = 0; i < 2; i++) begin
        inc_s[i]   = en_n[i];
        sref_s[i]  = en_n[i] & match_n[i];
        capld_s[i] = rise[i];
        scap_s[i]  = rise[i];
      end
      clr_s[0] = ~cfg.run_a | (sref_s[0] & mode_s[0][MB_RESTART]);
      clr_s[1] = ~cfg.run_b | (sref_s[1] & mode_s[1][MB_RESTART]);
    end
  end

  generate
    for (gi = 0; gi < 2; gi++) begin : g_slice
      tmr_slice #(.W(W)) u_slice (
        .clk     (clk),
        .rst_n   (rst_ns),
        .clr     (clr_s[gi]),
        .inc     (inc_s[gi]),
        .ld_cnt  (ld_s[gi]),
        .wr_ref  (wref_s[gi]),
        .wdat    (cas ? bus_wdata_i[gi*W +: W] : bus_wdata_i[W-1:0]),
        .wr_mode (wmode_s[gi]),
        .wr_evt  (wevt_s[gi]),
        .ctl     (bus_wdata_i[MODE_W-1:0]),
        .cap_ld  (capld_s[gi]),
        .set_ref (sref_s[gi]),
        .set_cap (scap_s[gi]),
        .cnt     (cnt_s[gi]),
        .refv    (ref_s[gi]),
        .cap     (cap_s[gi]),
        .mode    (mode_s[gi]),
        .evt     (evt_s[gi])
      );
    end
  endgenerate

  always_comb begin
    irq_o[0] = ~cas & (|(evt_s[0] & mode_s[0][EVT_W-1:0]));
    irq_o[1] = |(evt_s[1] & mode_s[1][EVT_W-1:0]);
  end

  logic [W-1:0] v0, v1;
  logic         wide_kind;

  always_comb begin
    v0 = '0;
    v1 = '0;
    wide_kind = 1'b0;
    bus_rdata_o = '0;
    case (rsel)
      RG_REF: begin v0 = ref_s[0]; v1 = ref_s[1]; wide_kind = 1'b1; end
      RG_CAP: begin v0 = cap_s[0]; v1 = cap_s[1]; wide_kind = 1'b1; end
      RG_CNT: begin v0 = cnt_s[0]; v1 = cnt_s[1]; wide_kind = 1'b1; end
      default: ;
    endcase
    if (rsel == RG_GCFG) begin
      if (!tsel) bus_rdata_o[7:0] = cfg;
    end else if (rsel == RG_MODE) begin
      bus_rdata_o[MODE_W-1:0] = tsel ? mode_s[1] : mode_s[0];
    end else if (rsel == RG_EVT) begin
      bus_rdata_o[EVT_W-1:0] = tsel ? evt_s[1] : evt_s[0];
    end else if (wide_kind) begin
      if (!cas)                    bus_rdata_o[W-1:0] = tsel ? v1 : v0;
      else if (bus_wide_i && tsel) bus_rdata_o = {v1, v0};
    end
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (!cas && en_n[0] && match_n[0] && mode_s[0][MB_RESTART]) |=> cnt_s[0] == '0); // R6
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_ns)
    (!cas && cfg.run_a && cfg.stop_a && !ld_s[0]) |=> $stable(cnt_s[0])); // R4
  AST_CAS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ns)
    (cas && rise[1]) |=> {cap_s[1], cap_s[0]} == $past({cnt_s[1], cnt_s[0]})); // R12
  AST_LOW_EVT_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    (cas && !wevt_s[0]) |=> $stable(evt_s[0])); // R13
  AST_CAS_CARRY: assert property (@(posedge clk) disable iff (!rst_ns)
    (cas && en_c && !wrap_c && !ld_s[0] && cfg.run_b && (&cnt_s[0]))
      |=> cnt_s[1] == $past(cnt_s[1]) + 1'b1); // R10
endmodule

// File: tb/tmr_pair_test.sv
`timescale 1ns/1ps
module tmr_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  cap = 2'b00;
  logic        en = 1'b0, we = 1'b0, wide = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_pair uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cap_i(cap),
    .bus_en_i(en), .bus_we_i(we), .bus_wide_i(wide), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic w);
    @(negedge clk);
    en = 1'b1; we = 1'b1; wide = w; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0; wide = 1'b0; wdata = 32'd0;
  endtask

  task automatic rd(input logic [3:0] a, input logic w, output logic [31:0] d);
    @(negedge clk);
    addr = a; wide = w;
    #1 d = rdata;
    wide = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    cap[idx] = 1'b1;
    repeat (5) @(negedge clk);
    cap[idx] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, 1'b0, d); check("R1 gcfg", d, 32'h0);
    rd(4'h4, 1'b0, d); check("R1 cnt0", d, 32'h0);
    rd(4'hB, 1'b0, d); check("R1 cap1", d, 32'h0);
    check("R1 irq", {30'd0, irq}, 32'h0);
  endtask

  task automatic t_gcfg();
    logic [31:0] d;
    wr(4'h0, 32'hFF, 1'b0);
    rd(4'h0, 1'b0, d); check("R2 reserved bits", d, 32'hBB);
    wr(4'h0, 32'h00, 1'b0);
  endtask

  task automatic t_run();
    logic [31:0] d;
    ticks(5);
    rd(4'h4, 1'b0, d); check("R3 held at zero", d, 32'h0);
    wr(4'h0, 32'h11, 1'b0);
    ticks(5);
    rd(4'h4, 1'b0, d); check("R3 count", d, 32'd5);
    rd(4'hC, 1'b0, d); check("R5 second equal", d, 32'd5);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(4'h0, 32'h13, 1'b0);
    ticks(4);
    rd(4'h4, 1'b0, d); check("R4 stopped", d, 32'd5);
    rd(4'hC, 1'b0, d); check("R4 other runs", d, 32'd9);
    wr(4'h4, 32'h100, 1'b0);
    rd(4'h4, 1'b0, d); check("R4 write while stopped", d, 32'h100);
    wr(4'h0, 32'h11, 1'b0);
    ticks(2);
    rd(4'h4, 1'b0, d); check("R4 resume", d, 32'h102);
  endtask

  task automatic t_match();
    logic [31:0] d;
    wr(4'h0, 32'h00, 1'b0);
    rd(4'h4, 1'b0, d); check("R3 clear on run=0", d, 32'h0);
    wr(4'h5, 32'h3, 1'b0);
    wr(4'hD, 32'h3, 1'b0);
    rd(4'h5, 1'b0, d); check("R9 clear all", d, 32'h0);
    wr(4'h1, 32'h5, 1'b0);
    wr(4'h2, 32'h3, 1'b0);
    wr(4'h0, 32'h11, 1'b0);
    ticks(4);
    rd(4'h4, 1'b0, d); check("R6 restart to zero", d, 32'h0);
    rd(4'h5, 1'b0, d); check("R6 ref event", d, 32'h1);
    check("R7 irq0 on ref", {30'd0, irq}, 32'h1);
    ticks(2);
    rd(4'h4, 1'b0, d); check("R6 after restart", d, 32'd2);
    rd(4'hC, 1'b0, d); check("R6 no restart keeps counting", d, 32'd6);
    rd(4'hD, 1'b0, d); check("R6 second ref event", d, 32'h1);
    check("R7 irq1 disabled", {30'd0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(4'h5, 32'h1, 1'b0);
    rd(4'h5, 1'b0, d); check("R9 cleared", d, 32'h0);
    check("R7 irq drops", {30'd0, irq}, 32'h0);
    wr(4'hD, 32'h2, 1'b0);
    rd(4'hD, 1'b0, d); check("R9 zero bit kept", d, 32'h1);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    wr(4'h1, 32'h2, 1'b0);
    pulse(0);
    rd(4'h3, 1'b0, d); check("R8 captured", d, 32'd2);
    rd(4'h5, 1'b0, d); check("R8 cap event", d, 32'h2);
    check("R7 irq0 on cap", {30'd0, irq}, 32'h1);
    rd(4'hB, 1'b0, d); check("R8 other capture untouched", d, 32'h0);
    wr(4'h5, 32'h2, 1'b0);
  endtask

  task automatic t_cascade();
    logic [31:0] d;
    wr(4'h0, 32'h00, 1'b0);
    wr(4'h0, 32'h90, 1'b0);
    wr(4'h1, 32'h0, 1'b0);
    wr(4'h9, 32'h5, 1'b0);
    wr(4'hA, 32'h0001_0002, 1'b1);
    wr(4'hC, 32'h0000_FFFE, 1'b1);
    wr(4'hD, 32'h3, 1'b0);
    wr(4'h5, 32'h3, 1'b0);
    ticks(2);
    rd(4'hC, 1'b1, d); check("R10 carry", d, 32'h0001_0000);
    rd(4'hA, 1'b1, d); check("R10 wide ref", d, 32'h0001_0002);
    rd(4'h4, 1'b0, d); check("R14 narrow read zero", d, 32'h0);
    ticks(3);
    rd(4'hC, 1'b1, d); check("R11 restart by second mode", d, 32'h0);
    rd(4'hD, 1'b0, d); check("R13 event in second", d, 32'h1);
    rd(4'h5, 1'b0, d); check("R13 first event quiet", d, 32'h0);
    check("R13 irq pattern", {30'd0, irq}, 32'h2);
    wr(4'hC, 32'h5555, 1'b0);
    wr(4'h4, 32'h7777, 1'b0);
    rd(4'hC, 1'b1, d); check("R14 narrow write ignored", d, 32'h0);
    wr(4'hC, 32'h0001_8000, 1'b1);
    pulse(0);
    rd(4'hB, 1'b1, d); check("R12 first input ignored", d, 32'h0000_0002);
    rd(4'hD, 1'b0, d); check("R12 no cap event", d, 32'h1);
    pulse(1);
    rd(4'hB, 1'b1, d); check("R12 32-bit capture", d, 32'h0001_8000);
    rd(4'hD, 1'b0, d); check("R12 cap event", d, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gcfg();
    t_run();
    t_stop();
    t_match();
    t_w1c();
    t_capture();
    t_cascade();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule